// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets clocked logic use an unclocked 64K x 1 static RAM that has a separate data-in pin and a separate data-out pin. A requester hands over one access at a time on a valid/ready interface. Each access carries a read/write flag, a 16-bit address and, for a write, one data bit. The controller drives the memory's active-low chip-select and write-enable. It also drives the address pins and the data-in pin, and it times the strobes so the memory's minimum widths are met.

The memory's timing limits are given in nanoseconds as parameters, together with the clock period. From these the controller derives the cycle counts it needs, each rounded up and never below one cycle. The access-time count sets how long a read waits before it samples the data-out pin. The sampled bit is registered and returned with a one-cycle response pulse. Writes are controlled by write-enable. Address and data are presented one cycle before both strobes fall. Both strobes then rise together, and the address and data are held for the hold count before the next request is taken.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises, mem_cs_no and mem_we_no are 1, req_ready_o is 1 and rsp_valid_o is 0.
- R2: A read (req_we_i = 0) drives the address and sets mem_cs_no = 0 in the cycle after acceptance, with mem_we_no = 1. mem_cs_no returns to 1 in the cycle the response is given, and rsp_valid_o is high for exactly one cycle with the stored bit on rsp_rdata_o.
- R3: A read's response appears exactly ACC_CYC = max(1, ceil(T_ACC_NS / CLK_NS)) cycles after the accepting edge. With the defaults this is 7.
- R4: A write (req_we_i = 1) presents the address and data one cycle with both strobes at 1. In the next cycle both mem_cs_no and mem_we_no are 0.
- R5: mem_we_no stays low for exactly WP_CYC = max(ceil(T_WP_NS / CLK_NS), ceil(T_DW_NS / CLK_NS), 1) cycles. With the defaults this is 5.
- R6: mem_we_no and mem_cs_no rise on the same edge. mem_we_no is never 0 while mem_cs_no is 1.
- R7: After the strobes rise at the end of a write, the address and data stay unchanged and req_ready_o stays 0 for DH_CYC = max(1, ceil(T_DH_NS / CLK_NS)) cycles. With the defaults this is 2.
- R8: req_ready_o is 0 from acceptance until the access completes. Requests offered in that time have no effect on the memory pins and cause no write.
- R9: mem_addr_o is unchanged in every cycle in which either strobe is 0 and was 0 in the previous cycle, and mem_din_o is unchanged while mem_we_no stays 0.
- R10: A write produces no response pulse, and a later read of the same address returns the bit written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request accepted on this edge if valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 1 | Write data bit |
| rsp_valid_o | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata_o | output | 1 | Read data bit |
| mem_cs_no | output | 1 | Memory chip-select, active low |
| mem_we_no | output | 1 | Memory write-enable, active low |
| mem_addr_o | output | 16 | Memory address pins |
| mem_din_o | output | 1 | Memory data-in pin |
| mem_dout_i | input | 1 | Memory data-out pin |

## Verification
A sequencer that leaves its state one cycle too early shows up at the ports as a read latency or write-pulse width that is off by one. It is seen on the first access. The bench's memory model returns an inverted bit until the access time has passed, so a read sampled too early also returns wrong data. A wrong hold count changes how long ready stays low after a write, and an address register that loads while busy moves the address pins in the middle of a strobe. Both show within a few cycles, and the second is also seen by a later read of the address that was offered.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WSETUP, ST_WPULSE, ST_WHOLD
  } seq_st_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned ACC_CYC = 7,
  parameter int unsigned WP_CYC  = 5,
  parameter int unsigned DH_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             zero_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o,
  output logic             cs_n_o,
  output logic             we_n_o
);
  seq_st_e st_q, st_d;
  logic    cs_n_q, cs_n_d, we_n_q, we_n_d;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    st_d       = st_q;
    cs_n_d     = cs_n_q;
    we_n_d     = we_n_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept_o) begin
        if (req_we_i) st_d = ST_WSETUP;
        else begin
          st_d       = ST_READ;
          cs_n_d     = 1'b0;
          load_o     = 1'b1;
          load_val_o = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_READ: if (zero_i) begin
        st_d      = ST_IDLE;
        cs_n_d    = 1'b1;
        capture_o = 1'b1;
      end
      ST_WSETUP: begin
        st_d       = ST_WPULSE;
        cs_n_d     = 1'b0;
        we_n_d     = 1'b0;
        load_o     = 1'b1;
        load_val_o = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: if (zero_i) begin
        st_d       = ST_WHOLD;
        cs_n_d     = 1'b1;
        we_n_d     = 1'b1;
        load_o     = 1'b1;
        load_val_o = CNT_W'(DH_CYC - 1);
      end
      ST_WHOLD: if (zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign we_n_o = we_n_q;

  // R6
  we_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> !cs_n_q);
  // R8
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_q |-> !ready_o);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_ACC_NS = 25,
  parameter int unsigned T_WP_NS  = 20,
  parameter int unsigned T_DW_NS  = 15,
  parameter int unsigned T_DH_NS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_rdata_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_din_o,
  input  logic              mem_dout_i
);
  localparam int unsigned ACC_CYC = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned WP_A    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned WP_B    = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int unsigned WP_CYC  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int unsigned DH_CYC  = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int unsigned MAX_AW  = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int unsigned MAX_CYC = (MAX_AW > DH_CYC) ? MAX_AW : DH_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, load, zero, capture;
  logic [CNT_W-1:0] load_val;
  logic [ADDR_W-1:0] addr_q;
  logic             din_q, rsp_q, rdata_q;

  sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .load_val_i(load_val), .zero_o(zero)
  );

  sram_seq #(
    .CNT_W(CNT_W), .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .DH_CYC(DH_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_we_i(req_we_i), .zero_i(zero), .ready_o(req_ready_o),
    .accept_o(accept), .load_o(load), .load_val_o(load_val),
    .capture_o(capture), .cs_n_o(mem_cs_no), .we_n_o(mem_we_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      din_q   <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= req_addr_i;
        din_q  <= req_wdata_i;
      end
      rsp_q <= capture;
      if (capture) rdata_q <= mem_dout_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_din_o   = din_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));
  // R9
  din_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> $stable(mem_din_o));
  // R2
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R6
  strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> $rose(mem_cs_no));

  // R5: pulse width counted here, the window depends on a parameter
  logic [CNT_W:0] we_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_lo_cnt <= '0;
    else if (!mem_we_no) we_lo_cnt <= we_lo_cnt + 1'b1;
    else                 we_lo_cnt <= '0;
  end
  // R5
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> ($past(we_lo_cnt) == (CNT_W+1)'(WP_CYC - 1)));
endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;
  localparam int CLK_NS = 4;
  localparam int ACC = (25 + CLK_NS - 1) / CLK_NS;
  localparam int WP  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int DH  = (5 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata, cs_n, we_n, din, dout;
  logic [15:0] maddr;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit rsp_in_write = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_cs_no(cs_n),
    .mem_we_no(we_n), .mem_addr_o(maddr), .mem_din_o(din), .mem_dout_i(dout)
  );

  // memory model: write in strobe overlap, data wrong until 25 ns after select/address
  bit  mem_m [int];
  time t_sel = 0;
  always @(cs_n, we_n, maddr, din) if (!cs_n && !we_n) mem_m[int'(maddr)] = din;
  always @(maddr or negedge cs_n) t_sel = $time;
  initial dout = 1'b0;
  always begin
    #1;
    if (cs_n || !we_n) dout = 1'b0;
    else begin
      bit v;
      v = mem_m.exists(int'(maddr)) ? mem_m[int'(maddr)] : 1'b0;
      dout = ($time - t_sel >= 25) ? v : ~v;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n && we_n && req_ready && !rsp_valid, "R1 in reset",
          {cs_n, we_n, req_ready, rsp_valid}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && we_n && req_ready && !rsp_valid, "R1 after reset",
          {cs_n, we_n, req_ready, rsp_valid}, 4'b1110);
  endtask

  task automatic t_write(logic [15:0] a, bit d, bit poke);
    int n, h;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(cs_n && we_n && maddr == a && din == d, "R4 setup",
          {cs_n, we_n, din}, {2'b11, d});
    @(negedge clk);
    check(!cs_n && !we_n, "R4 strobes", {cs_n, we_n}, 0);
    if (poke) begin
      req_valid = 1; req_we = 1; req_addr = ~a; req_wdata = ~d;
    end
    n = 1;
    @(negedge clk);
    if (poke) begin
      check(maddr == a && !req_ready, "R8 busy request ignored", maddr, a);
      req_valid = 0;
    end
    while (!we_n && n < 50) begin n++; @(negedge clk); end
    check(n == WP, "R5 write pulse width", n, WP);
    check(cs_n == 1, "R6 cs rises with we", cs_n, 1);
    h = 0;
    while (!req_ready && h < 50) begin
      if (maddr != a || din != d) check(0, "R7 address/data hold", maddr, a);
      h++; @(negedge clk);
    end
    check(h == DH, "R7 hold cycles", h, DH);
    check(!rsp_in_write, "R10 no response on write", rsp_in_write, 0);
  endtask

  task automatic t_read(logic [15:0] a, bit exp);
    int lat;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!cs_n && we_n && maddr == a && !req_ready, "R2 read strobes",
          {cs_n, we_n}, 2'b01);
    lat = 0;
    while (!rsp_valid && lat < 50) begin lat++; @(negedge clk); end
    check(lat == ACC, "R3 read latency", lat, ACC);
    check(rsp_rdata == exp, "R10 read data", rsp_rdata, exp);
    check(cs_n == 1, "R2 cs released at response", cs_n, 1);
    @(negedge clk);
    check(!rsp_valid, "R2 single response pulse", rsp_valid, 0);
  endtask

  always @(negedge clk) if (rsp_valid && !we_n) rsp_in_write = 1;

  initial begin
    t_reset();
    t_write(16'h1234, 1, 0);
    t_read(16'h1234, 1);
    t_write(16'h1234, 0, 0);
    t_read(16'h1234, 0);
    t_write(16'hFFFF, 1, 0);
    t_write(16'h0000, 1, 0);
    t_read(16'hFFFF, 1);
    t_read(16'h0000, 1);
    t_read(16'h5555, 0);
    t_write(16'h00F0, 1, 1);
    t_read(16'hFF0F, 0);   // R8: offered write never happened
    t_read(16'h00F0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule